// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Controller

This block turns a flat processor request into the strobe sequence that an asynchronous DRAM expects. A request supplies a full byte address, a read/write flag and a burst length. The controller sends the row half of the address on a narrow shared address bus while it pulls the active-low row strobe low. Then it swaps the column half onto the same pins and pulses the active-low column strobe. The address bits above the device address pick one module chip-select. Data lines bypass the block completely.

Between accesses the controller runs its own refresh. An interval counter, whose period comes from an input, marks a refresh as pending. At the next idle point the controller runs a row-strobe-only cycle on the row named by an internal refresh row counter, with every module selected. A pending refresh goes ahead of a waiting request, but it never breaks into an access that has already started. A burst keeps the row strobe low and issues consecutive column addresses, each with its own column-strobe pulse. An acknowledge pulse marks the end of each column pulse. All timing is counted in controller clock cycles and set by parameters.

Top module: `dram_mux_ctrl`

## Requirements
- R1: For an access, the 14-bit bus carries address bits [24:11] in the cycle the row strobe falls. It carries address bits [10:0], zero-extended to 14 bits, in the cycle the column strobe falls.
- R2: The first column strobe falls exactly RCD_CYC cycles (default 2) after the row strobe falls.
- R3: Both strobes are active low and sit high after reset. The column strobe is low only while the row strobe is low. Each column pulse stays low for exactly CAS_CYC cycles (default 2).
- R4: An access starts only when `req_i` is high while the controller is idle. While the access runs, `dram_wr_o` equals the `wr_i` value given with the request (1 = write).
- R5: Address bits [26:25] = k assert only `dram_cs_o[k]` for the whole access. No chip-select is asserted while idle.
- R6: With `burst_i` = N, one row-strobe period holds N+1 column pulses. The pulses use consecutive column addresses that wrap from 2047 to 0 within the same row, and the column strobe goes high for exactly one cycle between pulses.
- R7: If a refresh is pending and a request is waiting at the same idle point, the refresh goes first. Requests held high without a break do not starve refresh. The chip-selects do not change while the row strobe is low, so no refresh interrupts an access.
- R8: A refresh cycle drops the row strobe with all chip-selects high, and the column strobe stays high for the whole cycle. The bus carries the refresh row, which starts at 0 after reset, goes up by one with each refresh, and wraps from 16383 to 0.
- R9: `ack_o` is a one-cycle pulse in the last low cycle of each column pulse. There is exactly one pulse per beat.
- R10: With no traffic, row-strobe falls for refresh come exactly `ref_period_i` cycles apart.
- R11: After every row-strobe period, the row strobe stays high for at least PRE_CYC cycles (default 2) before it falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request, sampled while idle |
| addr_i | input | 27 | Byte address: module [26:25], row [24:11], column [10:0] |
| wr_i | input | 1 | 1 = write, 0 = read |
| burst_i | input | 4 | Number of extra consecutive columns |
| ref_period_i | input | 16 | Refresh interval in cycles |
| dram_addr_o | output | 14 | Multiplexed row/column address |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_cs_o | output | 4 | Module chip-selects, active high |
| dram_wr_o | output | 1 | Forwarded write flag |
| ack_o | output | 1 | Beat done (read data valid / write complete) |

## Verification
The scoreboard is run with single reads and writes to each of the four modules, so a wrong chip-select decode or swapped address halves shows up. Bursts are run from mid-row and across the last column, which separates a column counter that wraps inside the row from one that carries into the row. Requests are held high back to back with a short refresh period, to show that refresh takes priority without cutting into an access. A long idle run with a period of one steps the refresh row through its full wrap, and a quiet run with a longer period measures the refresh spacing exactly.

// File: rtl/dram_ctrl_pkg.sv
// Shared types for the multiplexed DRAM access controller.
// Assumes: one sequencer instance per controller.
package dram_ctrl_pkg;

    typedef enum logic [2:0] {
        S_IDLE,   // strobes high, waiting for refresh or request
        S_ACT,    // row strobe low, row on bus
        S_CAS,    // column strobe low, column on bus
        S_CGAP,   // column strobe high between burst beats
        S_PRE,    // both strobes high, precharge
        S_RACT    // refresh: row strobe only
    } seq_state_t;

endpackage

// File: rtl/dram_addr_split.sv
// Splits a flat byte address into row, column and a one-hot module select.
// Assumes: MOD_N >= 2 and module indexes above MOD_N-1 are never issued.
module dram_addr_split #(
    parameter int ROW_W = 14,
    parameter int COL_W = 11,
    parameter int MOD_N = 4
) (
    input  logic [ROW_W+COL_W+$clog2(MOD_N)-1:0] addr_i,
    output logic [ROW_W-1:0]                     row_o,
    output logic [COL_W-1:0]                     col_o,
    output logic [MOD_N-1:0]                     cs_o
);
    localparam int MOD_W = $clog2(MOD_N);
    localparam int DEV_W = ROW_W + COL_W;

    logic [MOD_W-1:0] mod_idx;

    // Field extraction: row above column, module above row.
    assign col_o   = addr_i[COL_W-1:0];
    assign row_o   = addr_i[DEV_W-1:COL_W];
    assign mod_idx = addr_i[DEV_W+MOD_W-1:DEV_W];

    // One decoder leg per module.
    for (genvar g = 0; g < MOD_N; g++) begin : g_cs
        assign cs_o[g] = (mod_idx == MOD_W'(g));
    end
endmodule

// File: rtl/dram_refresh_timer.sv
// Refresh interval counter and refresh row counter.
// Raises a pending flag every period_i cycles; the flag clears when the
// sequencer takes it. The row counter steps once per completed refresh.
// Assumes: period_i of 0 behaves like 1.
module dram_refresh_timer #(
    parameter int ROW_W  = 14,
    parameter int REFP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REFP_W-1:0] period_i,
    input  logic              take_i,
    input  logic              done_i,
    output logic              pend_o,
    output logic [ROW_W-1:0]  row_o
);
    logic [REFP_W-1:0] cnt;
    logic [REFP_W:0]   cnt_nx;
    logic              hit;

    assign cnt_nx = {1'b0, cnt} + {{REFP_W{1'b0}}, 1'b1};
    assign hit    = (cnt_nx >= {1'b0, period_i});

    // Interval counter; a new expiry wins over a same-cycle take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            pend_o <= 1'b0;
        end else begin
            if (hit) cnt <= '0;
            else     cnt <= cnt_nx[REFP_W-1:0];
            if (take_i) pend_o <= 1'b0;
            if (hit)    pend_o <= 1'b1;
        end
    end

    // Refresh row counter, wraps naturally after the last row.
    always_ff @(posedge clk) begin
        if (!rst_n)      row_o <= '0;
        else if (done_i) row_o <= row_o + ROW_W'(1);
    end

    AST_REF_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done_i) |-> (row_o == $past(row_o) + ROW_W'(1)));   // R8
    AST_PEND_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pend_o);                                           // R10
endmodule

// File: rtl/dram_seq_fsm.sv
// Strobe sequencer: row/column multiplexing, page-mode bursts,
// row-strobe-only refresh and precharge timing, all in clock cycles.
// Assumes: ROW_W >= COL_W; RCD_CYC, CAS_CYC, PRE_CYC >= 1.
module dram_seq_fsm
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W   = 14,
    parameter int COL_W   = 11,
    parameter int MOD_N   = 4,
    parameter int BURST_W = 4,
    parameter int RCD_CYC = 2,
    parameter int CAS_CYC = 2,
    parameter int PRE_CYC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic               wr_i,
    input  logic [ROW_W-1:0]   row_i,
    input  logic [COL_W-1:0]   col_i,
    input  logic [MOD_N-1:0]   cs_i,
    input  logic [BURST_W-1:0] burst_i,
    input  logic               ref_pend_i,
    input  logic [ROW_W-1:0]   ref_row_i,
    output logic               ras_n_o,
    output logic               cas_n_o,
    output logic [ROW_W-1:0]   addr_o,
    output logic [MOD_N-1:0]   cs_o,
    output logic               wr_o,
    output logic               ack_o,
    output logic               ref_take_o,
    output logic               ref_done_o
);
    localparam int REF_DUR = RCD_CYC + CAS_CYC;
    localparam int MAXD    = (REF_DUR > PRE_CYC) ? REF_DUR : PRE_CYC;
    localparam int CNT_W   = $clog2(MAXD + 1);

    seq_state_t          st;
    logic [CNT_W-1:0]    cnt;
    logic [ROW_W-1:0]    row_q;
    logic [COL_W-1:0]    col_q;
    logic [MOD_N-1:0]    cs_q;
    logic                wr_q;
    logic [BURST_W-1:0]  beats_q;
    logic                cnt_zero;

    assign cnt_zero   = (cnt == '0);
    assign ref_take_o = (st == S_IDLE) && ref_pend_i;
    assign ref_done_o = (st == S_RACT) && cnt_zero;
    assign ack_o      = (st == S_CAS) && cnt_zero;

    // State, cycle counter and latched request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            cnt     <= '0;
            row_q   <= '0;
            col_q   <= '0;
            cs_q    <= '0;
            wr_q    <= 1'b0;
            beats_q <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (ref_pend_i) begin
                        st  <= S_RACT;
                        cnt <= CNT_W'(REF_DUR - 1);
                    end else if (req_i) begin
                        st      <= S_ACT;
                        cnt     <= CNT_W'(RCD_CYC - 1);
                        row_q   <= row_i;
                        col_q   <= col_i;
                        cs_q    <= cs_i;
                        wr_q    <= wr_i;
                        beats_q <= burst_i;
                    end
                end
                S_ACT: begin
                    if (cnt_zero) begin
                        st  <= S_CAS;
                        cnt <= CNT_W'(CAS_CYC - 1);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                S_CAS: begin
                    if (!cnt_zero) begin
                        cnt <= cnt - CNT_W'(1);
                    end else if (beats_q != '0) begin
                        st      <= S_CGAP;
                        col_q   <= col_q + COL_W'(1);
                        beats_q <= beats_q - BURST_W'(1);
                    end else begin
                        st  <= S_PRE;
                        cnt <= CNT_W'(PRE_CYC - 1);
                    end
                end
                S_CGAP: begin
                    st  <= S_CAS;
                    cnt <= CNT_W'(CAS_CYC - 1);
                end
                S_RACT: begin
                    if (cnt_zero) begin
                        st  <= S_PRE;
                        cnt <= CNT_W'(PRE_CYC - 1);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                S_PRE: begin
                    if (cnt_zero) st <= S_IDLE;
                    else          cnt <= cnt - CNT_W'(1);
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Pin decode from the current state.
    always_comb begin
        ras_n_o = 1'b1;
        cas_n_o = 1'b1;
        addr_o  = row_q;
        cs_o    = '0;
        wr_o    = 1'b0;
        unique case (st)
            S_ACT: begin
                ras_n_o = 1'b0;
                cs_o    = cs_q;
                wr_o    = wr_q;
            end
            S_CAS: begin
                ras_n_o = 1'b0;
                cas_n_o = 1'b0;
                addr_o  = ROW_W'(col_q);
                cs_o    = cs_q;
                wr_o    = wr_q;
            end
            S_CGAP: begin
                ras_n_o = 1'b0;
                addr_o  = ROW_W'(col_q);
                cs_o    = cs_q;
                wr_o    = wr_q;
            end
            S_RACT: begin
                ras_n_o = 1'b0;
                addr_o  = ref_row_i;
                cs_o    = '1;
            end
            default: ;
        endcase
    end

    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n_o |-> !ras_n_o);                                    // R3
    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n_o |-> ($countones(cs_o) == 1));                     // R5
    AST_ACK_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !cas_n_o);                                       // R9
    AST_REF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && ref_pend_i) |=> (st == S_RACT));          // R7
    AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n_o && $past(!ras_n_o)) |-> $stable(cs_o));          // R7
    AST_COL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n_o && $past(!cas_n_o)) |-> $stable(addr_o));        // R6
endmodule

// File: rtl/dram_mux_ctrl.sv
// Top of the multiplexed DRAM access controller: address split,
// refresh timer and strobe sequencer. Data lines are not routed here.
// Assumes: synchronous active-low reset; MOD_N is a power of two >= 2.
module dram_mux_ctrl #(
    parameter int ROW_W   = 14,
    parameter int COL_W   = 11,
    parameter int MOD_N   = 4,
    parameter int BURST_W = 4,
    parameter int REFP_W  = 16,
    parameter int RCD_CYC = 2,
    parameter int CAS_CYC = 2,
    parameter int PRE_CYC = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_i,
    input  logic [ROW_W+COL_W+$clog2(MOD_N)-1:0] addr_i,
    input  logic                                 wr_i,
    input  logic [BURST_W-1:0]                   burst_i,
    input  logic [REFP_W-1:0]                    ref_period_i,
    output logic [ROW_W-1:0]                     dram_addr_o,
    output logic                                 dram_ras_n_o,
    output logic                                 dram_cas_n_o,
    output logic [MOD_N-1:0]                     dram_cs_o,
    output logic                                 dram_wr_o,
    output logic                                 ack_o
);
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic [MOD_N-1:0] req_cs;
    logic             ref_pend;
    logic             ref_take;
    logic             ref_done;
    logic [ROW_W-1:0] ref_row;

    dram_addr_split #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .MOD_N (MOD_N)
    ) split_i (
        .addr_i (addr_i),
        .row_o  (req_row),
        .col_o  (req_col),
        .cs_o   (req_cs)
    );

    dram_refresh_timer #(
        .ROW_W  (ROW_W),
        .REFP_W (REFP_W)
    ) refresh_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (ref_period_i),
        .take_i   (ref_take),
        .done_i   (ref_done),
        .pend_o   (ref_pend),
        .row_o    (ref_row)
    );

    dram_seq_fsm #(
        .ROW_W   (ROW_W),
        .COL_W   (COL_W),
        .MOD_N   (MOD_N),
        .BURST_W (BURST_W),
        .RCD_CYC (RCD_CYC),
        .CAS_CYC (CAS_CYC),
        .PRE_CYC (PRE_CYC)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .wr_i       (wr_i),
        .row_i      (req_row),
        .col_i      (req_col),
        .cs_i       (req_cs),
        .burst_i    (burst_i),
        .ref_pend_i (ref_pend),
        .ref_row_i  (ref_row),
        .ras_n_o    (dram_ras_n_o),
        .cas_n_o    (dram_cas_n_o),
        .addr_o     (dram_addr_o),
        .cs_o       (dram_cs_o),
        .wr_o       (dram_wr_o),
        .ack_o      (ack_o),
        .ref_take_o (ref_take),
        .ref_done_o (ref_done)
    );

    AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        dram_ras_n_o |-> (dram_cs_o == '0));                       // R5
endmodule

// File: tb/dram_mux_ctrl_tb.sv
// Scoreboard bench: the driver queues one expected beat per column pulse,
// the monitor checks strobes, bus contents and timing at each negedge.
module dram_mux_ctrl_tb_top;
    localparam int RCD = 2;
    localparam int CASW = 2;
    localparam int PRE = 2;
    localparam int WATCHDOG = 190000;

    typedef struct packed {
        logic [13:0] row;
        logic [10:0] col;
        logic [3:0]  cs;
        logic        wr;
        logic [4:0]  nb;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [26:0] addr = '0;
    logic        wr = 1'b0;
    logic [3:0]  burst = '0;
    logic [15:0] period = 16'hFFFF;
    logic [13:0] d_addr;
    logic        ras_n, cas_n, d_wr, ack;
    logic [3:0]  cs;

    always #5 clk = ~clk;

    dram_mux_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .addr_i       (addr),
        .wr_i         (wr),
        .burst_i      (burst),
        .ref_period_i (period),
        .dram_addr_o  (d_addr),
        .dram_ras_n_o (ras_n),
        .dram_cas_n_o (cas_n),
        .dram_cs_o    (cs),
        .dram_wr_o    (d_wr),
        .ack_o        (ack)
    );

    int    nvec = 0;
    int    nfail = 0;
    beat_t exp_q[$];
    int    exp_acks = 0;
    int    acks = 0;
    int    nref = 0;
    int    nacc = 0;
    bit    quiet = 1'b0;
    int    quiet_n = 0;
    bit    wrap_arm = 1'b0;
    bit    wrap_done = 1'b0;
    bit    finished = 1'b0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint expv);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
        end
    endtask

    // Monitor: pops expected beats and checks timing.
    longint      cyc = 0;
    bit          prev_ras = 1'b1, prev_cas = 1'b1;
    longint      ras_fall_c = 0, ras_rise_c = -1, cas_fall_c = 0, cas_rise_c = 0;
    longint      last_ref_c = 0;
    bit          in_ref = 1'b0;
    logic [3:0]  cs_at_fall = '0;
    logic [13:0] cur_row = '0;
    logic [13:0] exp_ref_row = '0;
    int          beats = 0, acc_nb = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_ras && !ras_n) begin
                if (ras_rise_c >= 0)
                    chk(cyc - ras_rise_c >= PRE, "R11", "precharge cycles", cyc - ras_rise_c, PRE);
                cs_at_fall = cs;
                if (cs == 4'hF) begin
                    in_ref = 1'b1;
                    chk(d_addr == exp_ref_row, "R8", "refresh row", d_addr, exp_ref_row);
                    if (wrap_arm) begin
                        chk(d_addr == 14'd0, "R8", "row after wrap", d_addr, 0);
                        wrap_done = 1'b1;
                        wrap_arm = 1'b0;
                    end
                    if (exp_ref_row == 14'h3FFF) wrap_arm = 1'b1;
                    exp_ref_row = exp_ref_row + 14'd1;
                    if (quiet) begin
                        if (quiet_n >= 2)
                            chk(cyc - last_ref_c == longint'(period), "R10", "refresh spacing",
                                cyc - last_ref_c, period);
                        quiet_n++;
                    end
                    last_ref_c = cyc;
                    nref++;
                end else begin
                    in_ref = 1'b0;
                    nacc++;
                    cur_row = d_addr;
                    beats = 0;
                    chk(exp_q.size() != 0, "R4", "access without request", 1, 0);
                    if (exp_q.size() != 0) begin
                        chk(d_addr == exp_q[0].row, "R1", "row on bus", d_addr, exp_q[0].row);
                        chk(cs == exp_q[0].cs, "R5", "chip select", cs, exp_q[0].cs);
                        chk(d_wr == exp_q[0].wr, "R4", "write flag", d_wr, exp_q[0].wr);
                        acc_nb = int'(exp_q[0].nb);
                    end
                end
                ras_fall_c = cyc;
            end
            if (!prev_ras && ras_n) begin
                if (!in_ref) chk(beats == acc_nb, "R6", "beats per row", beats, acc_nb);
                ras_rise_c = cyc;
            end
            if (!ras_n && !prev_ras)
                chk(cs == cs_at_fall, "R7", "cs held under row strobe", cs, cs_at_fall);
            if (!ras_n && in_ref)
                chk(cas_n == 1'b1, "R8", "column strobe during refresh", cas_n, 1);
            if (prev_cas && !cas_n) begin
                chk(!ras_n, "R3", "column strobe without row strobe", ras_n, 0);
                if (beats == 0)
                    chk(cyc - ras_fall_c == RCD, "R2", "row to column delay", cyc - ras_fall_c, RCD);
                else
                    chk(cyc - cas_rise_c == 1, "R6", "gap between pulses", cyc - cas_rise_c, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected column pulse", 1, 0);
                end else begin
                    beat_t it;
                    it = exp_q.pop_front();
                    chk(d_addr == {3'b000, it.col}, "R1", "column on bus", d_addr, it.col);
                    chk(it.row == cur_row, "R6", "row kept for burst", cur_row, it.row);
                    chk(d_wr == it.wr, "R4", "write flag at column", d_wr, it.wr);
                end
                beats++;
                cas_fall_c = cyc;
            end
            if (!prev_cas && cas_n) begin
                chk(cyc - cas_fall_c == CASW, "R3", "column pulse width", cyc - cas_fall_c, CASW);
                cas_rise_c = cyc;
            end
            if (ack) begin
                chk(!cas_n && (cyc - cas_fall_c == CASW - 1), "R9", "ack position",
                    cyc - cas_fall_c, CASW - 1);
                acks++;
            end
        end
        prev_ras = ras_n;
        prev_cas = cas_n;
    end

    // Driver: queue expected beats, then issue the request.
    task automatic do_access(input logic [26:0] a, input logic w, input int extra);
        for (int i = 0; i <= extra; i++) begin
            beat_t b;
            b.row = a[24:11];
            b.col = a[10:0] + 11'(i);
            b.cs  = 4'b0001 << a[26:25];
            b.wr  = w;
            b.nb  = 5'(extra + 1);
            exp_q.push_back(b);
        end
        exp_acks += extra + 1;
        @(negedge clk);
        req = 1'b1; addr = a; wr = w; burst = 4'(extra);
        do @(negedge clk); while (!ack);
        req = 1'b0;
        while (exp_q.size() != 0 || !ras_n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R4", "watchdog expired", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        int nref0, nacc0;
        repeat (3) @(negedge clk);
        chk(ras_n && cas_n, "R3", "strobes high in reset", {ras_n, cas_n}, 3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ras_n && cas_n, "R3", "strobes high after reset", {ras_n, cas_n}, 3);
        chk(cs == 4'h0, "R5", "no cs after reset", cs, 0);
        chk(ack == 1'b0, "R9", "no ack after reset", ack, 0);

        // No request: nothing starts (R4)
        nacc0 = nacc;
        repeat (40) @(negedge clk);
        chk(nacc == nacc0 && ras_n, "R4", "idle without request", nacc - nacc0, 0);

        // Single beats across modules and both directions (R1 R5 R4)
        do_access({2'd0, 14'h0001, 11'h002}, 1'b0, 0);
        do_access({2'd1, 14'h2AAA, 11'h555}, 1'b1, 0);
        do_access({2'd2, 14'h1555, 11'h2AA}, 1'b0, 0);
        do_access({2'd3, 14'h3FFF, 11'h7FF}, 1'b1, 0);
        // Bursts: mid-row and across the column wrap (R6)
        do_access({2'd1, 14'h0123, 11'h010}, 1'b0, 3);
        do_access({2'd2, 14'h0456, 11'h7FE}, 1'b1, 4);
        do_access({2'd0, 14'h3000, 11'h000}, 1'b0, 15);

        // Continuous requests with short refresh period (R7)
        period = 16'd30;
        nref0 = nref;
        for (int k = 0; k < 12; k++)
            do_access({2'(k), 14'(k * 77), 11'(k * 13)}, k[0], k % 3);
        chk(nref > nref0, "R7", "refresh under continuous requests", nref - nref0, 1);

        // Quiet spacing (R10)
        period = 16'd20;
        quiet = 1'b1;
        repeat (200) @(negedge clk);
        quiet = 1'b0;
        chk(quiet_n >= 5, "R10", "refreshes seen in quiet run", quiet_n, 5);

        // Back-to-back refresh until the row counter wraps (R8)
        period = 16'd1;
        while (!wrap_done) @(negedge clk);
        chk(wrap_done, "R8", "row counter wrapped", wrap_done, 1);
        period = 16'hFFFF;
        repeat (10) @(negedge clk);
        do_access({2'd3, 14'h0777, 11'h333}, 1'b1, 1);

        chk(acks == exp_acks, "R9", "ack count", acks, exp_acks);
        chk(exp_q.size() == 0, "R6", "beats outstanding", exp_q.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule